// File: doc/BRIEF.md
# Omega Multistage Request Router

This block connects a set of request sources, normally processor ports, to the same number of memory-side destinations. The path runs through log2(N) columns of 2x2 switching elements. Before each column the links are re-ordered by a perfect shuffle. Each request carries a destination index, and each column steers it by one bit of that index, starting with the most significant bit. Between any source and any destination there is exactly one route, so two requests can need the same switch output in the same cycle. When that happens, the request from the lower-numbered source passes and the other one is refused.

The router has no storage inside the switches. Its routing and contention logic is combinational. A single register stage at the output holds the delivered requests together with the per-source grant and stall flags, so every result appears one clock after its request. A source that is stalled keeps its request valid and offers it again on a later cycle. The block keeps no memory of earlier cycles.

Top module: `omega_net`

## Requirements
- R1: While reset is low, and on the first rising edge at which it is low, every output register is cleared. These are out_valid, out_data, out_src, grant and stall.
- R2: A request from source s to destination d that wins every column of switches appears one clock later on output port d. That port shows out_valid high, the request's payload on out_data and s on out_src. grant[s] is high in that same cycle.
- R3: A request presented alone always reaches its destination, for every source and destination pair.
- R4: One clock after a cycle, each source that had in_valid high shows exactly one of grant or stall. Each idle source shows neither.
- R5: When requests collide on a switch output, the one from the lower source index wins and the other is stalled. A request from source 0 is therefore never stalled.
- R6: Routing works as follows. Before every column, link p moves to position rotate-left(p) of its index bits. Switch s of a column takes positions 2s and 2s+1. Column k (k = 0 first) sends a request to its even (upper) output when destination bit AW-1-k is 0, and to its odd (lower) output when that bit is 1. Sources i and i+N/2 therefore share a first-column switch and collide exactly when their destination MSBs are equal. A request always leaves the last column on the link numbered with its destination.
- R7: The identity pattern (every source i to destination i) is routed with no stall. The bit-reversal pattern produces at least one stall.
- R8: The outcome of a cycle depends only on the requests presented in that cycle. A stalled source that presents its request again after its rival withdraws is granted.
- R9: If all sources target one destination, only source 0 is granted and all others are stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Request present, one bit per source |
| in_dest | input | N*AW | Destination index per source, source i in bits [i*AW +: AW] |
| in_data | input | N*DW | Payload per source, source i in bits [i*DW +: DW] |
| out_valid | output | N | A request is delivered on destination port j |
| out_data | output | N*DW | Delivered payload per destination port |
| out_src | output | N*AW | Source index of the delivered request per destination port |
| grant | output | N | Source's request was delivered this cycle |
| stall | output | N | Source's request was refused this cycle |

## Verification
Several properties are checked on every cycle. Each requester gets exactly one of grant or stall. The number of grants equals the number of delivered requests. Every delivered payload and source tag matches what that source presented on the previous cycle, aimed at that port. Source 0 is never refused, a lone request always gets through, and every request leaves the last column on the link named by its destination. Other behaviour can only be shown by the bench's scenarios, run against an independent route model. These are which source wins a particular collision, that sources i and i+N/2 meet in the first column, that the identity pattern passes cleanly while bit reversal does not, that a retried request is granted, and the hotspot outcome.

// File: rtl/omega_net.sv
`timescale 1ns/1ps
module omega_net #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      in_valid,
  input  logic [N*$clog2(N)-1:0] in_dest,
  input  logic [N*DW-1:0]   in_data,
  output logic [N-1:0]      out_valid,
  output logic [N*DW-1:0]   out_data,
  output logic [N*$clog2(N)-1:0] out_src,
  output logic [N-1:0]      grant,
  output logic [N-1:0]      stall
);
  localparam int AW  = $clog2(N);
  localparam int STG = AW;
  localparam int LW  = 1 + 2*AW + DW;
  localparam int VB  = LW - 1;
  localparam int SL  = DW + AW;
  localparam int DL  = DW;

  logic [LW-1:0] lnk [STG+1][N];
  logic [LW-1:0] shf [STG][N];
  logic [N-1:0]  won;

  genvar i, j, k, s;
  generate
    for (i = 0; i < N; i++) begin : g_in
      assign lnk[0][i] = {in_valid[i], AW'(i), in_dest[i*AW +: AW], in_data[i*DW +: DW]};
    end

    for (k = 0; k < STG; k++) begin : g_stage
      for (i = 0; i < N; i++) begin : g_shuffle
        localparam int Q = ((i << 1) | (i >> (AW-1))) % N;
        assign shf[k][Q] = lnk[k][i];
      end
      for (s = 0; s < N/2; s++) begin : g_sw
        logic [LW-1:0] a, b;
        logic ba, bb, a_first, ua, ub, la, lb;
        assign a       = shf[k][2*s];
        assign b       = shf[k][2*s+1];
        assign ba      = a[DL+AW-1-k];
        assign bb      = b[DL+AW-1-k];
        assign a_first = a[SL +: AW] < b[SL +: AW];
        assign ua      = a[VB] && !ba;
        assign ub      = b[VB] && !bb;
        assign la      = a[VB] && ba;
        assign lb      = b[VB] && bb;
        assign lnk[k+1][2*s]   = (ua && (!ub || a_first)) ? a : (ub ? b : '0);
        assign lnk[k+1][2*s+1] = (la && (!lb || a_first)) ? a : (lb ? b : '0);
      end
    end

    for (i = 0; i < N; i++) begin : g_won
      logic [N-1:0] hit;
      for (j = 0; j < N; j++) begin : g_hit
        assign hit[j] = lnk[STG][j][VB] && (lnk[STG][j][SL +: AW] == AW'(i));
      end
      assign won[i] = |hit;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
      grant     <= '0;
      stall     <= '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        out_valid[p]           <= lnk[STG][p][VB];
        out_data[p*DW +: DW]   <= lnk[STG][p][DL-1:0];
        out_src[p*AW +: AW]    <= lnk[STG][p][SL +: AW];
      end
      grant <= won;
      stall <= in_valid & ~won;
    end
  end

  a_r4_grant_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((grant | stall) == $past(in_valid)) && ((grant & stall) == '0));

  a_r2_grant_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == $countones(out_valid));

  a_r3_lone_request: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) == 1) |=> ($countones(grant) == 1));

  a_r5_source0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[0] |=> grant[0]);

  generate
    for (j = 0; j < N; j++) begin : g_chk_out
      a_r6_lands_on_dest: assert property (@(posedge clk) disable iff (!rst_n)
        lnk[STG][j][VB] |-> (lnk[STG][j][DL +: AW] == AW'(j)));
      for (i = 0; i < N; i++) begin : g_chk_src
        a_r2_delivery: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(rst_n) && out_valid[j] && out_src[j*AW +: AW] == AW'(i)) |->
            ($past(in_valid[i]) && $past(in_dest[i*AW +: AW]) == AW'(j) &&
             out_data[j*DW +: DW] == $past(in_data[i*DW +: DW]) && grant[i]));
      end
    end
  endgenerate
endmodule

// File: tb/omega_net_tb.sv
`timescale 1ns/1ps
module omega_net_tb;
  localparam int N = 8, AW = 3, DW = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [N-1:0]    in_valid = '0;
  logic [N*AW-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    out_valid, grant, stall;
  logic [N*DW-1:0] out_data;
  logic [N*AW-1:0] out_src;

  omega_net #(.N(N), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_src(out_src), .grant(grant), .stall(stall));

  int checks = 0, fails = 0;
  logic [N-1:0] tv;
  int td[N];
  logic [15:0] seed = 16'h5a3c;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] data_of(int i);
    return seed ^ 16'(i * 4951);
  endfunction

  task automatic apply();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_valid[i] = tv[i];
      in_dest[i*AW +: AW] = td[i][AW-1:0];
      in_data[i*DW +: DW] = data_of(i);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_case(string tag);
    logic [N-1:0] alive;
    int owner[N];
    apply();
    alive = tv;
    for (int k = 0; k < AW; k++) begin
      for (int j = 0; j < N; j++) owner[j] = -1;
      for (int s = 0; s < N; s++) begin
        if (alive[s]) begin
          int l;
          l = ((s << (k+1)) | (td[s] >> (AW-1-k))) & (N-1);
          if (owner[l] >= 0) alive[s] = 1'b0;
          else owner[l] = s;
        end
      end
    end
    chk(grant == alive, tag, "grant", grant, alive);
    chk(stall == (tv & ~alive), tag, "stall", stall, tv & ~alive);
    for (int j = 0; j < N; j++) begin
      bit ev; int es;
      ev = 0; es = 0;
      for (int s = 0; s < N; s++) if (alive[s] && td[s] == j) begin ev = 1; es = s; end
      chk(out_valid[j] == ev, tag, "out_valid", out_valid[j], ev);
      if (ev) begin
        chk(out_src[j*AW +: AW] == AW'(es), tag, "out_src", out_src[j*AW +: AW], es);
        chk(out_data[j*DW +: DW] == data_of(es), tag, "out_data", out_data[j*DW +: DW], data_of(es));
      end
    end
    seed = seed * 16'd25173 + 16'd13849;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0 && grant == 0 && stall == 0, "R1", "outputs in reset",
        {out_valid, grant, stall}, 0);
    chk(out_data == 0 && out_src == 0, "R1", "data in reset", out_data, 0);
    rst_n = 1;
  endtask

  task automatic t_single();
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        tv = '0; tv[s] = 1'b1; td[s] = d;
        run_case("R2");
        chk(grant == tv && stall == 0, "R3", "lone grant", grant, tv);
      end
  endtask

  task automatic t_stage0_pair();
    tv = 8'h11; td[0] = 0; td[4] = 1;
    run_case("R6");
    chk(grant == 8'h01, "R6", "first-column collision grant", grant, 8'h01);
    chk(stall == 8'h10, "R5", "higher source stalled", stall, 8'h10);
    tv = 8'h10;
    run_case("R8");
    chk(grant == 8'h10 && out_valid == 8'h02, "R8", "retry granted", {grant, out_valid}, 16'h1002);
    tv = 8'h03; td[0] = 0; td[1] = 1;
    run_case("R6");
    chk(grant == 8'h03, "R6", "separate switches no collision", grant, 8'h03);
  endtask

  task automatic t_permutations();
    tv = '1;
    for (int i = 0; i < N; i++) td[i] = i;
    run_case("R7");
    chk(grant == 8'hff && stall == 0, "R7", "identity clean", grant, 8'hff);
    for (int i = 0; i < N; i++) td[i] = {i[0], i[1], i[2]};
    run_case("R7");
    chk(stall != 0, "R7", "bit reversal stalls", stall, 1);
  endtask

  task automatic t_hotspot();
    tv = '1;
    for (int i = 0; i < N; i++) td[i] = 5;
    run_case("R9");
    chk(grant == 8'h01 && stall == 8'hfe, "R9", "hotspot", {grant, stall}, 16'h01fe);
    chk(out_valid == 8'h20, "R5", "hotspot port", out_valid, 8'h20);
  endtask

  task automatic t_idle();
    tv = '0;
    run_case("R4");
    chk(grant == 0 && stall == 0 && out_valid == 0, "R4", "idle", {grant, stall, out_valid}, 0);
  endtask

  task automatic t_mixed();
    logic [15:0] lf;
    lf = 16'hace1;
    for (int n = 0; n < 24; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tv = lf[7:0];
      for (int i = 0; i < N; i++) td[i] = (lf >> i) % N;
      run_case("R4");
    end
  endtask

  task automatic t_reset_mid();
    tv = '1;
    for (int i = 0; i < N; i++) td[i] = i;
    run_case("R2");
    @(negedge clk); rst_n = 0;
    @(posedge clk); @(negedge clk);
    chk(out_valid == 0 && grant == 0 && stall == 0 && out_data == 0, "R1", "reset clears",
        {out_valid, grant, stall}, 0);
    rst_n = 1;
    tv = '0;
    run_case("R1");
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) td[i] = 0;
    tv = '0;
    repeat (3) @(posedge clk);
    t_reset();
    t_idle();
    t_single();
    t_stage0_pair();
    t_permutations();
    t_hotspot();
    t_mixed();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule